// File: doc/BRIEF.md
# 16-bit Memory-Form Effective Address Decoder

This block turns the addressing byte of an instruction (the mod and rm fields) into the parts of a 16-bit memory operand. It reports an optional base register, an optional index register, a scale of one, and a displacement with the correct sign. The byte arrives on a ready/valid input together with two mode flags. The block selects the 16-bit memory forms only when the core is outside 64-bit mode and an address-size override is present. It then takes zero, one or two displacement bytes from a byte-serial ready/valid input.

The result fields are registered. A one-cycle done pulse marks the cycle in which they are valid. The fields keep their values until the next addressing byte is accepted. No scaled-index byte is ever requested in this mode. An addressing byte the block cannot decode raises an error flag together with done and yields no operand. Such a byte is either a register-direct form or one presented outside the 16-bit address mode.

Top module: `memform16_decode`

## Requirements
- R1: After reset, modrmReady is 1, dispReady is 0 and done is 0. modrmReady is high only while no operand is in progress, and dispReady only while a displacement byte is awaited. The two are never high together.
- R2: The 16-bit forms are decoded only when longMode=0 and addrOverride=1. Any other mode combination gives done with err=1, baseValid=0, indexValid=0, dispCount=0 and disp=0.
- R3: A byte with mod=11 (bits 7:6) gives done with err=1, no base, no index, dispCount=0 and disp=0.
- R4: For mod=01 or 10, and for mod=00 with rm other than 110, the rm field (bits 2:0) selects base and index. 000 gives BX+SI, 001 gives BX+DI, 010 gives BP+SI and 011 gives BP+DI. 100 gives SI, 101 gives DI, 110 gives BP and 111 gives BX, each with no index. The register codes are BX=3, BP=5, SI=6 and DI=7.
- R5: mod=00 with rm=110 gives no base and no index, and reads a two-byte displacement.
- R6: mod=00 with rm other than 110 reads no displacement byte, and disp is 0.
- R7: mod=01 reads one displacement byte and sign-extends it to DISP_W bits.
- R8: mod=10 reads two displacement bytes. The first byte received is the low byte. The 16-bit value is sign-extended to DISP_W bits.
- R9: No extra byte is requested for rm=100. After a mod=00, rm=100 operand, dispReady stays 0.
- R10: done is high for exactly one cycle. That cycle follows the clock edge at which the final byte of the operand was accepted: the last displacement byte, or the addressing byte when no displacement is needed.
- R11: scale reads 1 at all times. dispCount reports the number of displacement bytes read (0, 1 or 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modrmValid | input | 1 | Addressing byte offered |
| modrmReady | output | 1 | Block can accept an addressing byte |
| modrmByte | input | 8 | Addressing byte (mod 7:6, reg 5:3, rm 2:0) |
| longMode | input | 1 | Core is in 64-bit mode, sampled with the addressing byte |
| addrOverride | input | 1 | Address-size override present, sampled with the addressing byte |
| dispValid | input | 1 | Displacement byte offered |
| dispReady | output | 1 | Block can accept a displacement byte |
| dispByte | input | 8 | Displacement byte |
| done | output | 1 | One-cycle pulse: result fields valid |
| err | output | 1 | Byte not decodable as a 16-bit memory form |
| baseValid | output | 1 | A base register is used |
| baseReg | output | 3 | Base register code |
| indexValid | output | 1 | An index register is used |
| indexReg | output | 3 | Index register code |
| scale | output | 4 | Index multiplier, always 1 |
| disp | output | DISP_W | Sign-extended displacement |
| dispCount | output | 2 | Displacement bytes read |

## Verification
Several rules are checked by embedded properties on every cycle. The two input handshakes are exclusive, and dispReady only rises after an addressing-byte handshake. Every done follows a handshake. An error result carries no operand, an index never appears without a base, and a form without a base has a two-byte displacement. A one-byte result always has its upper bits equal to bit 7.

Only the directed scenarios can show the rest. They cover the exact base and index codes for each of the 24 memory forms, and little-endian assembly of the two bytes. They also cover the mode gating, the exact timing of done under stalled displacement bytes, and the absence of a request for a scaled-index byte.

// File: rtl/memform16_pkg.sv
package memform16_pkg;

  localparam logic [2:0] REG_BX = 3'd3;
  localparam logic [2:0] REG_BP = 3'd5;
  localparam logic [2:0] REG_SI = 3'd6;
  localparam logic [2:0] REG_DI = 3'd7;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2
  } ctrlState_t;

  typedef struct packed {
    logic loadForm;
    logic takeLo;
    logic takeHi;
  } dpStrobe_t;

endpackage

// File: rtl/memform16_table.sv
module memform16_table
  import memform16_pkg::*;
(
  input  logic [7:0] modrm,
  input  logic       longMode,
  input  logic       addrOverride,
  output logic       formErr,
  output logic [1:0] needBytes,
  output logic       tblBaseValid,
  output logic [2:0] tblBaseReg,
  output logic       tblIndexValid,
  output logic [2:0] tblIndexReg
);

  logic [1:0] modField;
  logic [2:0] rmField;
  logic       unusedRegBits;
  logic       bareDisp;

  assign modField      = modrm[7:6];
  assign rmField       = modrm[2:0];
  assign unusedRegBits = ^modrm[5:3];
  assign formErr       = longMode || !addrOverride || (modField == 2'b11);
  assign bareDisp      = (modField == 2'b00) && (rmField == 3'b110);

  always_comb begin
    needBytes = 2'd0;
    if (!formErr) begin
      case (modField)
        2'b01:   needBytes = 2'd1;
        2'b10:   needBytes = 2'd2;
        default: needBytes = bareDisp ? 2'd2 : 2'd0;
      endcase
    end
  end

  always_comb begin
    tblBaseValid  = 1'b1;
    tblIndexValid = 1'b0;
    tblBaseReg    = REG_BX;
    tblIndexReg   = REG_SI;
    case (rmField)
      3'b000: begin tblBaseReg = REG_BX; tblIndexReg = REG_SI; tblIndexValid = 1'b1; end
      3'b001: begin tblBaseReg = REG_BX; tblIndexReg = REG_DI; tblIndexValid = 1'b1; end
      3'b010: begin tblBaseReg = REG_BP; tblIndexReg = REG_SI; tblIndexValid = 1'b1; end
      3'b011: begin tblBaseReg = REG_BP; tblIndexReg = REG_DI; tblIndexValid = 1'b1; end
      3'b100: tblBaseReg = REG_SI;
      3'b101: tblBaseReg = REG_DI;
      3'b110: tblBaseReg = REG_BP;
      default: tblBaseReg = REG_BX;
    endcase
    if (formErr || bareDisp) begin
      tblBaseValid  = 1'b0;
      tblIndexValid = 1'b0;
    end
  end

endmodule

// File: rtl/memform16_ctrl.sv
module memform16_ctrl
  import memform16_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       modrmValid,
  input  logic       dispValid,
  input  logic       formErr,
  input  logic [1:0] needBytes,
  output logic       modrmReady,
  output logic       dispReady,
  output dpStrobe_t  strobe,
  output logic       done
);

  ctrlState_t state, nextState;
  logic       wideDisp;
  logic       doneNxt;

  always_comb begin
    nextState  = state;
    strobe     = '0;
    doneNxt    = 1'b0;
    modrmReady = (state == ST_IDLE);
    dispReady  = (state != ST_IDLE);
    case (state)
      ST_IDLE: if (modrmValid) begin
        strobe.loadForm = 1'b1;
        if (formErr || needBytes == 2'd0) doneNxt = 1'b1;
        else                              nextState = ST_LO;
      end
      ST_LO: if (dispValid) begin
        strobe.takeLo = 1'b1;
        if (wideDisp) nextState = ST_HI;
        else begin
          doneNxt   = 1'b1;
          nextState = ST_IDLE;
        end
      end
      ST_HI: if (dispValid) begin
        strobe.takeHi = 1'b1;
        doneNxt       = 1'b1;
        nextState     = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      wideDisp <= 1'b0;
      done     <= 1'b0;
    end else begin
      state <= nextState;
      done  <= doneNxt;
      if (strobe.loadForm) wideDisp <= (needBytes == 2'd2);
    end
  end

  // R1
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({modrmReady, dispReady}));

  // R1
  disp_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dispReady) |-> $past(modrmValid && modrmReady));

  // R10
  done_after_hs_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(modrmValid && modrmReady) || $past(dispValid && dispReady)));

endmodule

// File: rtl/memform16_dp.sv
module memform16_dp
  import memform16_pkg::*;
#(
  parameter int DISP_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              formErr,
  input  logic [1:0]        needBytes,
  input  logic              tblBaseValid,
  input  logic [2:0]        tblBaseReg,
  input  logic              tblIndexValid,
  input  logic [2:0]        tblIndexReg,
  input  logic [7:0]        dispByte,
  input  logic              done,
  output logic              err,
  output logic              baseValid,
  output logic [2:0]        baseReg,
  output logic              indexValid,
  output logic [2:0]        indexReg,
  output logic [DISP_W-1:0] disp,
  output logic [1:0]        dispCount
);

  localparam int TOP = DISP_W - 1;

  logic [15:0] wideWord;
  assign wideWord = {dispByte, disp[7:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      err        <= 1'b0;
      baseValid  <= 1'b0;
      baseReg    <= '0;
      indexValid <= 1'b0;
      indexReg   <= '0;
      disp       <= '0;
      dispCount  <= '0;
    end else begin
      if (strobe.loadForm) begin
        err        <= formErr;
        baseValid  <= tblBaseValid;
        baseReg    <= tblBaseReg;
        indexValid <= tblIndexValid;
        indexReg   <= tblIndexReg;
        dispCount  <= formErr ? 2'd0 : needBytes;
        disp       <= '0;
      end
      if (strobe.takeLo) disp <= DISP_W'(signed'(dispByte));
      if (strobe.takeHi) disp <= DISP_W'(signed'(wideWord));
    end
  end

  // R2 R3
  err_no_operand_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && err) |-> (!baseValid && !indexValid && dispCount == 2'd0 && disp == '0));

  // R4
  index_needs_base_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && indexValid) |-> baseValid);

  // R5
  bare_disp16_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !err && !baseValid) |-> (dispCount == 2'd2));

  // R7
  sext8_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && dispCount == 2'd1) |-> ((&disp[TOP:7]) || !(|disp[TOP:7])));

endmodule

// File: rtl/memform16_decode.sv
module memform16_decode
  import memform16_pkg::*;
#(
  parameter int DISP_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modrmValid,
  output logic              modrmReady,
  input  logic [7:0]        modrmByte,
  input  logic              longMode,
  input  logic              addrOverride,
  input  logic              dispValid,
  output logic              dispReady,
  input  logic [7:0]        dispByte,
  output logic              done,
  output logic              err,
  output logic              baseValid,
  output logic [2:0]        baseReg,
  output logic              indexValid,
  output logic [2:0]        indexReg,
  output logic [3:0]        scale,
  output logic [DISP_W-1:0] disp,
  output logic [1:0]        dispCount
);

  dpStrobe_t  strobe;
  logic       formErr;
  logic [1:0] needBytes;
  logic       tblBaseValid, tblIndexValid;
  logic [2:0] tblBaseReg, tblIndexReg;

  assign scale = 4'd1;

  memform16_table u_table (
    .modrm        (modrmByte),
    .longMode     (longMode),
    .addrOverride (addrOverride),
    .formErr      (formErr),
    .needBytes    (needBytes),
    .tblBaseValid (tblBaseValid),
    .tblBaseReg   (tblBaseReg),
    .tblIndexValid(tblIndexValid),
    .tblIndexReg  (tblIndexReg)
  );

  memform16_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .modrmValid(modrmValid),
    .dispValid (dispValid),
    .formErr   (formErr),
    .needBytes (needBytes),
    .modrmReady(modrmReady),
    .dispReady (dispReady),
    .strobe    (strobe),
    .done      (done)
  );

  memform16_dp #(.DISP_W(DISP_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .formErr      (formErr),
    .needBytes    (needBytes),
    .tblBaseValid (tblBaseValid),
    .tblBaseReg   (tblBaseReg),
    .tblIndexValid(tblIndexValid),
    .tblIndexReg  (tblIndexReg),
    .dispByte     (dispByte),
    .done         (done),
    .err          (err),
    .baseValid    (baseValid),
    .baseReg      (baseReg),
    .indexValid   (indexValid),
    .indexReg     (indexReg),
    .disp         (disp),
    .dispCount    (dispCount)
  );

endmodule

// File: tb/memform16_decode_tb.sv
module memform16_decode_tb;

  localparam int DISP_W = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              modrmValid = 1'b0;
  logic              modrmReady;
  logic [7:0]        modrmByte = '0;
  logic              longMode = 1'b0;
  logic              addrOverride = 1'b1;
  logic              dispValid = 1'b0;
  logic              dispReady;
  logic [7:0]        dispByte = '0;
  logic              done, err, baseValid, indexValid;
  logic [2:0]        baseReg, indexReg;
  logic [3:0]        scale;
  logic [DISP_W-1:0] disp;
  logic [1:0]        dispCount;

  int checkCnt = 0;
  int failCnt  = 0;

  always #2.5 clk = ~clk;

  memform16_decode #(.DISP_W(DISP_W)) u_dut (
    .clk(clk), .rstN(rstN), .modrmValid(modrmValid), .modrmReady(modrmReady),
    .modrmByte(modrmByte), .longMode(longMode), .addrOverride(addrOverride),
    .dispValid(dispValid), .dispReady(dispReady), .dispByte(dispByte),
    .done(done), .err(err), .baseValid(baseValid), .baseReg(baseReg),
    .indexValid(indexValid), .indexReg(indexReg), .scale(scale),
    .disp(disp), .dispCount(dispCount)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  endtask

  // Expected operand computed from the requirements, then driven and compared.
  task automatic runOp(input logic [7:0] m, input logic lm, input logic ov,
                       input logic [7:0] b0, input logic [7:0] b1, input int gap);
    logic [1:0]  md;
    logic [2:0]  rm;
    logic        eErr, eBV, eIV, bare;
    logic [2:0]  eBR, eIR;
    int          need;
    logic [31:0] eDisp;
    string       tagF, tagD;
    logic [7:0]  bytesIn [2];
    md = m[7:6];
    rm = m[2:0];
    bytesIn[0] = b0;
    bytesIn[1] = b1;
    eErr = lm || !ov || md == 2'b11;
    bare = (md == 2'b00) && (rm == 3'b110);
    need = eErr ? 0 : (md == 2'b01) ? 1 : (md == 2'b10) ? 2 : bare ? 2 : 0;
    eIV = 1'b0; eIR = 3'd0;
    case (rm)
      3'd0: begin eBR = 3'd3; eIR = 3'd6; eIV = 1'b1; end
      3'd1: begin eBR = 3'd3; eIR = 3'd7; eIV = 1'b1; end
      3'd2: begin eBR = 3'd5; eIR = 3'd6; eIV = 1'b1; end
      3'd3: begin eBR = 3'd5; eIR = 3'd7; eIV = 1'b1; end
      3'd4: eBR = 3'd6;
      3'd5: eBR = 3'd7;
      3'd6: eBR = 3'd5;
      default: eBR = 3'd3;
    endcase
    eBV = !(eErr || bare);
    if (eErr || bare) eIV = 1'b0;
    if (need == 1)      eDisp = {{24{b0[7]}}, b0};
    else if (need == 2) eDisp = {{16{b1[7]}}, b1, b0};
    else                eDisp = 32'd0;
    tagF = eErr ? ((md == 2'b11) ? "R3" : "R2") : (bare ? "R5" : "R4");
    tagD = eErr ? tagF : bare ? "R5" : (md == 2'b01) ? "R7" : (md == 2'b10) ? "R8" : "R6";

    @(negedge clk);
    chk("R1", "modrmReady idle", {31'd0, modrmReady}, 32'd1);
    modrmByte = m; longMode = lm; addrOverride = ov; modrmValid = 1'b1;
    @(negedge clk);
    modrmValid = 1'b0;
    for (int i = 0; i < need; i++) begin
      for (int g = 0; g < gap; g++) begin
        chk("R10", "done early", {31'd0, done}, 32'd0);
        @(negedge clk);
      end
      chk("R10", "done early", {31'd0, done}, 32'd0);
      chk("R1", "dispReady", {31'd0, dispReady}, 32'd1);
      chk("R1", "modrmReady busy", {31'd0, modrmReady}, 32'd0);
      dispByte = bytesIn[i]; dispValid = 1'b1;
      @(negedge clk);
      dispValid = 1'b0;
    end
    chk("R10", "done pulse", {31'd0, done}, 32'd1);
    chk(tagF, "err", {31'd0, err}, {31'd0, eErr});
    chk(tagF, "baseValid", {31'd0, baseValid}, {31'd0, eBV});
    if (eBV) chk(tagF, "baseReg", {29'd0, baseReg}, {29'd0, eBR});
    chk(tagF, "indexValid", {31'd0, indexValid}, {31'd0, eIV});
    if (eIV) chk(tagF, "indexReg", {29'd0, indexReg}, {29'd0, eIR});
    chk(tagD, "disp", disp, eDisp);
    chk("R11", "dispCount", {30'd0, dispCount}, need);
    chk("R11", "scale", {28'd0, scale}, 32'd1);
    @(negedge clk);
    chk("R10", "done single cycle", {31'd0, done}, 32'd0);
    if (need == 0) chk("R9", "no extra byte requested", {31'd0, dispReady}, 32'd0);
  endtask

  task automatic testReset();
    chk("R1", "reset modrmReady", {31'd0, modrmReady}, 32'd1);
    chk("R1", "reset dispReady", {31'd0, dispReady}, 32'd0);
    chk("R1", "reset done", {31'd0, done}, 32'd0);
    chk("R11", "reset scale", {28'd0, scale}, 32'd1);
  endtask

  task automatic testAllForms();
    for (int md = 0; md < 3; md++)
      for (int rm = 0; rm < 8; rm++)
        runOp({md[1:0], 3'b010, rm[2:0]}, 1'b0, 1'b1,
              8'h80 + 8'(rm * 17), 8'h7E + 8'(md * 64), 0);
  endtask

  task automatic testSignCases();
    runOp(8'b01_000_011, 1'b0, 1'b1, 8'h80, 8'h00, 0);   // R7 negative
    runOp(8'b01_000_110, 1'b0, 1'b1, 8'h7F, 8'h00, 0);   // R7 positive, BP base
    runOp(8'b00_000_110, 1'b0, 1'b1, 8'h01, 8'h80, 0);   // R5 negative disp16
    runOp(8'b10_000_111, 1'b0, 1'b1, 8'hFE, 8'hFF, 0);   // R8
    runOp(8'b10_000_010, 1'b0, 1'b1, 8'h34, 8'h12, 3);   // R8 stalled bytes, R10
  endtask

  task automatic testErrors();
    runOp(8'b11_000_000, 1'b0, 1'b1, 8'h55, 8'h55, 0);   // R3
    runOp(8'b01_000_000, 1'b1, 1'b1, 8'h55, 8'h55, 0);   // R2 long mode
    runOp(8'b10_000_001, 1'b0, 1'b0, 8'h55, 8'h55, 0);   // R2 no override
    runOp(8'b00_000_100, 1'b0, 1'b1, 8'h00, 8'h00, 0);   // R9 after errors
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testAllForms();
    testSignCases();
    testErrors();
    finishRun();
  end

endmodule